// File: doc/BRIEF.md
# Serial CRC-32 Accumulator with Serial Read-Out

This block folds a serial bit stream into a 32-bit cyclic redundancy check, one bit per clock, using the reflected form of the common 32-bit generator polynomial. Once the last data bit has been absorbed, the same register becomes a right-shifting output register. The check value then leaves the block least significant bit first, on a one-bit output, without any second copy of the value.

A controller drives three strobes: a clear that re-seeds the register, an update strobe that absorbs the bit on the serial input, and a shift strobe that moves the register one place toward the serial output. If more than one strobe is high in a cycle, only the highest-priority one acts. The whole register is also visible in parallel, so neighbouring logic can compare it with a received check word. The block runs on the test clock. It has a synchronous active-low reset, which is a separate input from the clear.

Top module: `serial_crc_shifter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `crc_q` becomes 0xFFFFFFFF on that edge, whatever `clr`, `upd_en` and `shift_en` are.
- R2: When `clr` is high at a rising edge, `crc_q` becomes 0xFFFFFFFF, even if `upd_en` or `shift_en` is also high.
- R3: When `upd_en` is high and `clr` is low at an edge, the register takes the value (old >> 1) XOR (0xEDB88320 if old[0] XOR `bit_in` is 1, else 0).
- R4: Feeding the nine ASCII bytes "123456789" from a cleared register, each byte least significant bit first, leaves `crc_q` at 0x340BC6D9.
- R5: When `shift_en` is high and both `clr` and `upd_en` are low, the register moves right one place and bit 31 becomes 0.
- R6: When `upd_en` and `shift_en` are both high and `clr` is low, only the update of R3 takes place.
- R7: When none of `clr`, `upd_en` and `shift_en` is high, the register keeps its value, and `bit_in` has no effect on it.
- R8: `ser_out` always equals bit 0 of `crc_q`. After 32 shifts, the values seen on `ser_out` rebuild the earlier register value least significant bit first, and the register then reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads all ones |
| clr | input | 1 | Synchronous re-seed to all ones; highest priority |
| upd_en | input | 1 | Absorb `bit_in` into the check value this cycle |
| shift_en | input | 1 | Shift the register toward `ser_out` this cycle |
| bit_in | input | 1 | Serial data bit used by an update |
| crc_q | output | 32 | Parallel view of the register |
| ser_out | output | 1 | Serial output; the register's least significant bit |

## Verification
Every cycle, the checker confirms each transition against the previous register value: the re-seed after reset or clear, the polynomial step, the zero-filling shift, and the hold when no strobe is high. These checks also cover the strobe priority. The checker cannot tell that a whole message gives the right check value, or that 32 shifts hand out the value in the right bit order. Those are shown by the bench scenarios: the nine-byte test string against its known residue, the rebuild of the value from `ser_out`, and a reset in the middle of a stream.

// File: rtl/serial_crc_pkg.sv
// Shared definitions for the serial CRC accumulator.
// Assumes one operation per cycle, chosen by a fixed priority.
package serial_crc_pkg;

    // Operation applied to the register on the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SEED   = 2'd1,
        OP_ABSORB = 2'd2,
        OP_SHIFT  = 2'd3
    } crc_op_e;

endpackage

// File: rtl/crc_op_decode.sv
// Strobe decoder: turns the three control strobes into one operation.
// Assumes the priority clear > update > shift. Any strobe below the
// winner is ignored for that cycle.
module crc_op_decode
    import serial_crc_pkg::*;
(
    input  logic    clr,
    input  logic    upd_en,
    input  logic    shift_en,
    output crc_op_e op
);

    // Priority select among the strobes.
    always_comb begin
        if (clr)           op = OP_SEED;
        else if (upd_en)   op = OP_ABSORB;
        else if (shift_en) op = OP_SHIFT;
        else               op = OP_HOLD;
    end

endmodule

// File: rtl/crc_lfsr_step.sv
// One-bit step of a reflected CRC, with a parameterised width and
// polynomial. Each bit is built separately, so the XOR taps come from
// the polynomial parameter. Purely combinational.
module crc_lfsr_step #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    POLY = 32'hEDB88320
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    output logic [W-1:0] nxt
);

    logic feedback;

    // Feedback: the bit leaving the register mixed with the data bit.
    always_comb feedback = cur[0] ^ din;

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == W - 1) begin : g_top
            // The top bit gets only the tap, since a zero enters there.
            always_comb nxt[i] = feedback & POLY[i];
        end else begin : g_mid
            // The other bits take their upper neighbour plus the tap.
            always_comb nxt[i] = cur[i+1] ^ (feedback & POLY[i]);
        end
    end

endmodule

// File: rtl/crc_state_reg.sv
// Register for the check value, with a synchronous active-low reset
// to a parameterised seed. Assumes the caller has already chosen the
// next value.
module crc_state_reg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Store the next value, or the seed while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= d;
    end

endmodule

// File: rtl/serial_crc_shifter.sv
// Serial CRC accumulator whose register also acts as its own output
// shift register. Assumes the controller strobes one bit per cycle and
// raises shift_en only after the last data bit has been absorbed.
module serial_crc_shifter #(
    parameter int               CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320,
    parameter logic [CRC_W-1:0] SEED  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd_en,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q,
    output logic             ser_out
);
    import serial_crc_pkg::*;

    crc_op_e          op;
    logic [CRC_W-1:0] absorbed;
    logic [CRC_W-1:0] shifted;
    logic [CRC_W-1:0] next_val;

    crc_op_decode u_dec (
        .clr      (clr),
        .upd_en   (upd_en),
        .shift_en (shift_en),
        .op       (op)
    );

    crc_lfsr_step #(.W(CRC_W), .POLY(POLY)) u_step (
        .cur (crc_q),
        .din (bit_in),
        .nxt (absorbed)
    );

    // Shift toward the serial output, filling the top with zero.
    always_comb shifted = {1'b0, crc_q[CRC_W-1:1]};

    // Choose the next register value from the decoded operation.
    always_comb begin
        case (op)
            OP_SEED:   next_val = SEED;
            OP_ABSORB: next_val = absorbed;
            OP_SHIFT:  next_val = shifted;
            default:   next_val = crc_q;
        endcase
    end

    crc_state_reg #(.W(CRC_W), .SEED(SEED)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_val),
        .q     (crc_q)
    );

    // Serial output: the bit that the next shift drops.
    always_comb ser_out = crc_q[0];

endmodule

// File: rtl/serial_crc_shifter_chk.sv
// Cycle checker for serial_crc_shifter, attached with bind below.
module serial_crc_shifter_chk #(
    parameter int               CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320,
    parameter logic [CRC_W-1:0] SEED  = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             upd_en,
    input logic             shift_en,
    input logic             bit_in,
    input logic [CRC_W-1:0] crc_q
);

    a_r1_reset_seed: assert property (@(posedge clk)
        !rst_n |=> (crc_q == SEED));

    a_r2_clear_seed: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == SEED));

    // Covers R3 and R6, since a shift strobe may also be high here.
    a_r3_absorb_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && upd_en) |=>
        (crc_q == (($past(crc_q) >> 1) ^
                   (($past(crc_q[0]) ^ $past(bit_in)) ? POLY : '0))));

    a_r5_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd_en && shift_en) |=>
        (crc_q == {1'b0, $past(crc_q[CRC_W-1:1])}));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !upd_en && !shift_en) |=> $stable(crc_q));

endmodule

bind serial_crc_shifter serial_crc_shifter_chk #(
    .CRC_W (CRC_W),
    .POLY  (POLY),
    .SEED  (SEED)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .upd_en   (upd_en),
    .shift_en (shift_en),
    .bit_in   (bit_in),
    .crc_q    (crc_q)
);

// File: tb/serial_crc_shifter_tb_top.sv
`timescale 1ns/1ps
module serial_crc_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        upd_en = 1'b0;
    logic        shift_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [31:0] crc_q;
    logic        ser_out;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] model = 32'hFFFFFFFF;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    serial_crc_shifter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .upd_en   (upd_en),
        .shift_en (shift_en),
        .bit_in   (bit_in),
        .crc_q    (crc_q),
        .ser_out  (ser_out)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive one cycle from a negedge, advance the model, compare at the next negedge.
    task automatic step(input logic c, input logic u, input logic s, input logic b, input string tag);
        logic fb;
        clr = c; upd_en = u; shift_en = s; bit_in = b;
        if (!rst_n || c) model = 32'hFFFFFFFF;
        else if (u) begin
            fb = model[0] ^ b;
            model = model >> 1;
            if (fb) model = model ^ 32'hEDB88320;
        end else if (s) model = model >> 1;
        @(posedge clk);
        @(negedge clk);
        check32(tag, crc_q, model);
        check32("R8 ser_out", {31'd0, ser_out}, {31'd0, model[0]});
    endtask

    task automatic feed_byte(input logic [7:0] byt, input string tag);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b0, byt[k], tag);
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] saved;
        logic [31:0] rebuilt;
        string msg;
        @(negedge clk);
        step(1'b0, 1'b1, 1'b1, 1'b1, "R1 reset wins over strobes");
        check32("R1 reset value", crc_q, 32'hFFFFFFFF);
        rst_n = 1'b1;

        // R7: no strobes, bit_in toggles
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, k[0], "R7 hold ignores bit_in");
        check32("R7 held seed", crc_q, 32'hFFFFFFFF);

        // R3/R4: known test string
        msg = "123456789";
        for (int k = 0; k < 9; k++) feed_byte(msg[k], "R3 absorb");
        check32("R4 test string residue", crc_q, 32'h340BC6D9);
        saved = crc_q;

        step(1'b0, 1'b0, 1'b0, 1'b1, "R7 hold after data");
        check32("R7 value kept", crc_q, saved);

        // R5/R8: shift out and rebuild
        rebuilt = '0;
        for (int k = 0; k < 32; k++) begin
            rebuilt[k] = ser_out;
            step(1'b0, 1'b0, 1'b1, 1'b1, "R5 shift");
        end
        check32("R8 rebuilt from ser_out", rebuilt, saved);
        check32("R8 empty after 32 shifts", crc_q, 32'h0);

        // R2: clear, also against other strobes
        step(1'b1, 1'b0, 1'b0, 1'b0, "R2 clear");
        check32("R2 clear value", crc_q, 32'hFFFFFFFF);
        feed_byte(8'hA5, "R3 absorb A5");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R2 clear beats update and shift");
        check32("R2 clear priority", crc_q, 32'hFFFFFFFF);

        // R6: update beats shift
        feed_byte(8'h3C, "R3 absorb 3C");
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b1, k[1], "R6 update over shift");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6 update over shift single");

        // R3: all-zero and all-one data
        feed_byte(8'h00, "R3 absorb zeros");
        feed_byte(8'hFF, "R3 absorb ones");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b1, 1'b0, "R5 partial shift");

        // R1: reset in mid stream with clear low
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b0, 1'b1, "R1 reset mid stream");
        check32("R1 reseeded", crc_q, 32'hFFFFFFFF);
        rst_n = 1'b1;
        feed_byte(8'h5A, "R3 absorb after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule